// File: doc/BRIEF.md
# Associative Page Address Translator

This block turns a virtual word address into a real core-store address. The core store is split into page frames. Each frame has one associative register that holds the virtual block number now resident in it. On every request the block number is compared with all registers in parallel. A single match is encoded into a frame number, and that number is joined to the untranslated line bits. A request whose block is not resident produces a page-fault indication, and the supervisor is expected to bring the page in.

Each register also carries three flags. A valid flag keeps empty frames from matching. A lock-out flag refuses ordinary program accesses to a resident page but still lets accesses from the transfer engine through; a refused access is reported as a protection violation. A use flag is set whenever an access is granted. It is exported as a vector so that an external replacement policy can read it. The supervisor loads and clears entries through a single write port. The result is registered, one cycle after the request.

Top module: `assoc_page_translator`

## Requirements
- R1: On a granted access the real address is the matching frame index (log2 of FRAMES bits) in the upper bits, followed by the LINE_W low bits of the virtual address, unchanged.
- R2: Every response appears exactly one clock after its request. `rsp_valid` is high in that cycle and low in a cycle that follows no request.
- R3: When exactly one valid register holds the requested block number (the upper BLK_W bits of the virtual address) and that register is not locked, the response has `rsp_hit` high and `rsp_fault` and `rsp_viol` low.
- R4: When no valid register holds the requested block, `rsp_fault` is high, and `rsp_hit`, `rsp_viol` and `rsp_raddr` are all zero.
- R5: A register whose valid flag is clear never matches, whatever block number it holds.
- R6: A single match on a locked register, from a program access (`req_xfer` = 0), gives `rsp_viol` high with `rsp_hit` and `rsp_fault` low and `rsp_raddr` zero. The use flag of that register is not set.
- R7: A single match on a locked register, from a transfer-engine access (`req_xfer` = 1), is granted exactly as in R3.
- R8: A granted access sets bit f of `use_flags` in the same clock edge that presents the response, where f is the matching frame. Faults, violations and multi-hits leave every use flag unchanged.
- R9: A supervisor write to frame f replaces the block, valid and lock-out values of frame f from the next cycle on and clears bit f of `use_flags`. A request in the same cycle as the write is looked up against the old contents. If a grant and a write hit the same frame in the same cycle, the write wins.
- R10: When two or more valid registers match, `rsp_multi` and `rsp_fault` are high and `rsp_hit` and `rsp_viol` are low. No use flag is set.
- R11: After reset every entry is invalid and unlocked, `use_flags` is zero and all response outputs are zero.
- R12: In a cycle with `rsp_valid` high exactly one of `rsp_hit`, `rsp_fault` and `rsp_viol` is high. With `rsp_valid` low all three and `rsp_multi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A translation request is present |
| req_vaddr | input | BLK_W+LINE_W | Virtual word address: block number above line bits |
| req_xfer | input | 1 | 1 = request from the transfer engine, 0 = program access |
| sup_we | input | 1 | Supervisor write strobe |
| sup_frame | input | log2(FRAMES) | Frame register to write |
| sup_block | input | BLK_W | Block number to load |
| sup_valid | input | 1 | Valid flag to load |
| sup_lock | input | 1 | Lock-out flag to load |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_raddr | output | log2(FRAMES)+LINE_W | Real address, zero unless hit |
| rsp_hit | output | 1 | Access granted |
| rsp_fault | output | 1 | Page fault (miss or multi-hit) |
| rsp_viol | output | 1 | Protection violation on a locked page |
| rsp_multi | output | 1 | More than one register matched |
| use_flags | output | FRAMES | Per-frame use flags |

## Verification
The bench builds the translator with 8 frames, a 5-bit block number and 3 line bits. With these values all 32 block numbers can be swept against the table under both source tags, so every block gets a lookup in each table state. The table states are empty, partly loaded with one invalid frame, and partly locked. Because the configuration is this small, every frame's use flag can be tracked against an arithmetic model. It also lets a duplicate entry be planted on purpose to produce a multi-hit, and a write can be made to collide with a lookup of the same frame.

// File: rtl/apt_pkg.sv
// Package: shared types for the associative page translator.
// Assumes: nothing beyond IEEE 1800-2017.
package apt_pkg;

    // Classification of one lookup before it is registered.
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_FAULT = 2'd2,
        OUT_VIOL  = 2'd3
    } apt_outcome_e;

endpackage

// File: rtl/apt_frame_bank.sv
// Module: apt_frame_bank
// Holds one associative register per page frame: block number, valid,
// lock-out and use flag. It compares the requested block with every
// entry in parallel and drives one match line and one lock line per frame.
// Assumes: the supervisor write wins over a use-flag set to the same frame.
module apt_frame_bank #(
    parameter int FRAMES  = 32,
    parameter int BLK_W   = 11,
    localparam int FRAME_W = $clog2(FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BLK_W-1:0]   look_block,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [BLK_W-1:0]   wr_block,
    input  logic               wr_valid,
    input  logic               wr_lock,
    input  logic [FRAMES-1:0]  use_set,
    output logic [FRAMES-1:0]  match_vec,
    output logic [FRAMES-1:0]  lock_vec,
    output logic [FRAMES-1:0]  use_vec
);

    logic [BLK_W-1:0] ent_block [FRAMES];
    logic [FRAMES-1:0] ent_valid;
    logic [FRAMES-1:0] ent_lock;
    logic [FRAMES-1:0] ent_use;

    for (genvar i = 0; i < FRAMES; i++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_frame == FRAME_W'(i));

        // Entry contents: loaded only by the supervisor write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_block[i] <= '0;
                ent_valid[i] <= 1'b0;
                ent_lock[i]  <= 1'b0;
            end else if (sel) begin
                ent_block[i] <= wr_block;
                ent_valid[i] <= wr_valid;
                ent_lock[i]  <= wr_lock;
            end
        end

        // Use flag: cleared by a write, set by a granted access.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_use[i] <= 1'b0;
            end else if (sel) begin
                ent_use[i] <= 1'b0;
            end else if (use_set[i]) begin
                ent_use[i] <= 1'b1;
            end
        end

        // Parallel compare: a valid entry holding the requested block.
        assign match_vec[i] = ent_valid[i] && (ent_block[i] == look_block);
        assign lock_vec[i]  = ent_lock[i];
    end

    assign use_vec = ent_use;

endmodule

// File: rtl/apt_match_encode.sv
// Module: apt_match_encode
// Encodes the match lines into a frame index by OR-ing the indices of
// the set lines. It also reports whether any line and whether more than
// one line is set.
// Assumes: the index is meaningful only when exactly one line is set.
module apt_match_encode #(
    parameter int FRAMES  = 32,
    localparam int FRAME_W = $clog2(FRAMES)
) (
    input  logic [FRAMES-1:0]  match_vec,
    output logic [FRAME_W-1:0] frame_idx,
    output logic               any_match,
    output logic               multi_match
);

    // Encoder and duplicate detector in a single pass over the lines.
    always_comb begin
        frame_idx   = '0;
        any_match   = 1'b0;
        multi_match = 1'b0;
        for (int i = 0; i < FRAMES; i++) begin
            if (match_vec[i]) begin
                if (any_match) begin
                    multi_match = 1'b1;
                end
                any_match = 1'b1;
                frame_idx = frame_idx | FRAME_W'(i);
            end
        end
    end

endmodule

// File: rtl/apt_resp_stage.sv
// Module: apt_resp_stage
// Classifies a lookup as hit, fault or violation, forms the real address
// and registers the response. It also emits the grant used for use flags.
// Assumes: the inputs come from the same cycle as req_valid.
module apt_resp_stage
    import apt_pkg::*;
#(
    parameter int FRAME_W = 5,
    parameter int LINE_W  = 9,
    localparam int RA_W   = FRAME_W + LINE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_xfer,
    input  logic [LINE_W-1:0]  req_line,
    input  logic [FRAME_W-1:0] frame_idx,
    input  logic               any_match,
    input  logic               multi_match,
    input  logic               hit_locked,
    output logic               grant,
    output logic               rsp_valid,
    output logic [RA_W-1:0]    rsp_raddr,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic               rsp_viol,
    output logic               rsp_multi
);

    apt_outcome_e outcome;

    // Decide the outcome: multi-hit and miss fault, lock blocks programs.
    always_comb begin
        if (!req_valid) begin
            outcome = OUT_NONE;
        end else if (!any_match || multi_match) begin
            outcome = OUT_FAULT;
        end else if (hit_locked && !req_xfer) begin
            outcome = OUT_VIOL;
        end else begin
            outcome = OUT_HIT;
        end
    end

    assign grant = (outcome == OUT_HIT);

    // Response register: one cycle of latency from request to result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_raddr <= '0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_viol  <= 1'b0;
            rsp_multi <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_raddr <= grant ? {frame_idx, req_line} : '0;
            rsp_hit   <= grant;
            rsp_fault <= (outcome == OUT_FAULT);
            rsp_viol  <= (outcome == OUT_VIOL);
            rsp_multi <= req_valid && multi_match;
        end
    end

endmodule

// File: rtl/assoc_page_translator.sv
// Module: assoc_page_translator (top)
// Fully associative virtual-to-real page translation. There is one register
// per core frame, with lock-out and use flags, and a supervisor write port.
// Assumes: the supervisor keeps block numbers unique; duplicates are
// detected and reported as faults.
module assoc_page_translator #(
    parameter int BLK_W   = 11,
    parameter int LINE_W  = 9,
    parameter int FRAMES  = 32,
    localparam int FRAME_W = $clog2(FRAMES),
    localparam int VA_W    = BLK_W + LINE_W,
    localparam int RA_W    = FRAME_W + LINE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_xfer,
    input  logic               sup_we,
    input  logic [FRAME_W-1:0] sup_frame,
    input  logic [BLK_W-1:0]   sup_block,
    input  logic               sup_valid,
    input  logic               sup_lock,
    output logic               rsp_valid,
    output logic [RA_W-1:0]    rsp_raddr,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic               rsp_viol,
    output logic               rsp_multi,
    output logic [FRAMES-1:0]  use_flags
);

    logic [FRAMES-1:0]  match_vec;
    logic [FRAMES-1:0]  lock_vec;
    logic [FRAMES-1:0]  use_set;
    logic [FRAME_W-1:0] frame_idx;
    logic               any_match;
    logic               multi_match;
    logic               hit_locked;
    logic               grant;

    apt_frame_bank #(.FRAMES(FRAMES), .BLK_W(BLK_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_block (req_vaddr[VA_W-1:LINE_W]),
        .wr_en      (sup_we),
        .wr_frame   (sup_frame),
        .wr_block   (sup_block),
        .wr_valid   (sup_valid),
        .wr_lock    (sup_lock),
        .use_set    (use_set),
        .match_vec  (match_vec),
        .lock_vec   (lock_vec),
        .use_vec    (use_flags)
    );

    apt_match_encode #(.FRAMES(FRAMES)) u_enc (
        .match_vec   (match_vec),
        .frame_idx   (frame_idx),
        .any_match   (any_match),
        .multi_match (multi_match)
    );

    // Lock state of the matching register (one-hot case only is used).
    assign hit_locked = |(match_vec & lock_vec);

    // A granted access marks its own frame as used.
    assign use_set = match_vec & {FRAMES{grant}};

    apt_resp_stage #(.FRAME_W(FRAME_W), .LINE_W(LINE_W)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_xfer    (req_xfer),
        .req_line    (req_vaddr[LINE_W-1:0]),
        .frame_idx   (frame_idx),
        .any_match   (any_match),
        .multi_match (multi_match),
        .hit_locked  (hit_locked),
        .grant       (grant),
        .rsp_valid   (rsp_valid),
        .rsp_raddr   (rsp_raddr),
        .rsp_hit     (rsp_hit),
        .rsp_fault   (rsp_fault),
        .rsp_viol    (rsp_viol),
        .rsp_multi   (rsp_multi)
    );

endmodule

// File: rtl/apt_checker.sv
// Module: apt_checker
// Temporal checks on the translator ports, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module apt_checker #(
    parameter int BLK_W   = 11,
    parameter int LINE_W  = 9,
    parameter int FRAMES  = 32,
    localparam int FRAME_W = $clog2(FRAMES),
    localparam int VA_W    = BLK_W + LINE_W,
    localparam int RA_W    = FRAME_W + LINE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               req_xfer,
    input logic               sup_we,
    input logic [FRAME_W-1:0] sup_frame,
    input logic               rsp_valid,
    input logic [RA_W-1:0]    rsp_raddr,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic               rsp_viol,
    input logic               rsp_multi,
    input logic [FRAMES-1:0]  use_flags
);

    AST_LINE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_raddr[LINE_W-1:0] == $past(req_vaddr[LINE_W-1:0])); // R1

    AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2

    AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_raddr == '0); // R4

    AST_VIOL_PROGRAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_viol |-> !$past(req_xfer)); // R6

    AST_WRITE_CLEARS_USE: assert property (@(posedge clk) disable iff (!rst_n)
        sup_we |=> !use_flags[$past(sup_frame)]); // R9

    AST_MULTI_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> (rsp_fault && !rsp_hit && !rsp_viol)); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_fault, rsp_viol})); // R12

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_viol || rsp_multi)); // R12

endmodule

bind assoc_page_translator apt_checker #(
    .BLK_W  (BLK_W),
    .LINE_W (LINE_W),
    .FRAMES (FRAMES)
) u_apt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .req_xfer  (req_xfer),
    .sup_we    (sup_we),
    .sup_frame (sup_frame),
    .rsp_valid (rsp_valid),
    .rsp_raddr (rsp_raddr),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_viol  (rsp_viol),
    .rsp_multi (rsp_multi),
    .use_flags (use_flags)
);

// File: tb/tb_assoc_page_translator.sv
module tb_assoc_page_translator;

    localparam int CLK_PERIOD = 10;
    localparam int BLK_W  = 5;
    localparam int LINE_W = 3;
    localparam int FRAMES = 8;
    localparam int FW     = 3;
    localparam int NBLK   = 1 << BLK_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [BLK_W+LINE_W-1:0] req_vaddr = '0;
    logic              req_xfer = 1'b0;
    logic              sup_we = 1'b0;
    logic [FW-1:0]     sup_frame = '0;
    logic [BLK_W-1:0]  sup_block = '0;
    logic              sup_valid = 1'b0;
    logic              sup_lock = 1'b0;
    logic              rsp_valid;
    logic [FW+LINE_W-1:0] rsp_raddr;
    logic              rsp_hit, rsp_fault, rsp_viol, rsp_multi;
    logic [FRAMES-1:0] use_flags;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_blk  [FRAMES];
    bit m_val  [FRAMES];
    bit m_lock [FRAMES];
    bit [FRAMES-1:0] m_use = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc_page_translator #(.BLK_W(BLK_W), .LINE_W(LINE_W), .FRAMES(FRAMES)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_xfer(req_xfer), .sup_we(sup_we), .sup_frame(sup_frame),
        .sup_block(sup_block), .sup_valid(sup_valid), .sup_lock(sup_lock),
        .rsp_valid(rsp_valid), .rsp_raddr(rsp_raddr), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault), .rsp_viol(rsp_viol), .rsp_multi(rsp_multi),
        .use_flags(use_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a lookup (optionally with a simultaneous supervisor write) and
    // check the registered response against the model.
    task automatic lookup(input int blk, input int line, input bit xf,
                          input bit wr, input int wf, input int wb,
                          input bit wv, input bit wl);
        int nm = 0;
        int fi = 0;
        bit lk = 0;
        bit e_hit, e_fault, e_viol, e_multi;
        int e_addr;
        string tag;
        for (int f = 0; f < FRAMES; f++) begin
            if (m_val[f] && m_blk[f] == blk) begin
                nm++; fi = f; lk = m_lock[f];
            end
        end
        e_multi = (nm > 1);
        e_fault = (nm != 1);
        e_viol  = (nm == 1) && lk && !xf;
        e_hit   = (nm == 1) && !(lk && !xf);
        e_addr  = e_hit ? (fi * (1 << LINE_W) + line) : 0;
        if (e_multi)       tag = "R10";
        else if (e_fault)  tag = "R4,R5";
        else if (e_viol)   tag = "R6";
        else if (lk)       tag = "R7,R1";
        else               tag = "R3,R1";
        if (e_hit) m_use[fi] = 1'b1;
        if (wr) begin
            m_blk[wf] = wb; m_val[wf] = wv; m_lock[wf] = wl; m_use[wf] = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {blk[BLK_W-1:0], line[LINE_W-1:0]};
        req_xfer  = xf;
        sup_we    = wr;
        sup_frame = wf[FW-1:0];
        sup_block = wb[BLK_W-1:0];
        sup_valid = wv;
        sup_lock  = wl;
        @(negedge clk);
        check({tag, " response"},
              {22'd0, rsp_valid, rsp_hit, rsp_fault, rsp_viol, rsp_multi, rsp_raddr},
              {22'd0, 1'b1, e_hit, e_fault, e_viol, e_multi, e_addr[FW+LINE_W-1:0]});
        check(wr ? "R9 use flags" : "R8 use flags", {24'd0, use_flags}, {24'd0, m_use});
        req_valid = 1'b0;
        sup_we    = 1'b0;
    endtask

    task automatic sup_write(input int f, input int b, input bit v, input bit l);
        @(negedge clk);
        sup_we = 1'b1; sup_frame = f[FW-1:0]; sup_block = b[BLK_W-1:0];
        sup_valid = v; sup_lock = l;
        m_blk[f] = b; m_val[f] = v; m_lock[f] = l; m_use[f] = 1'b0;
        @(negedge clk);
        sup_we = 1'b0;
        check("R9 write clears use", {24'd0, use_flags}, {24'd0, m_use});
    endtask

    task automatic sweep(input int seed);
        for (int b = 0; b < NBLK; b++) begin
            for (int x = 0; x < 2; x++) begin
                lookup(b, (b + seed + x) % (1 << LINE_W), x[0], 1'b0, 0, 0, 1'b0, 1'b0);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int f = 0; f < FRAMES; f++) begin
            m_blk[f] = 0; m_val[f] = 0; m_lock[f] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state, no entries, no flags
        check("R11 reset outputs",
              {24'd0, rsp_valid, rsp_hit, rsp_fault, rsp_viol, rsp_multi, 3'd0},
              32'd0);
        check("R11 reset raddr", {26'd0, rsp_raddr}, 32'd0);
        check("R11 reset use flags", {24'd0, use_flags}, 32'd0);

        // Empty table: every block faults (R4, R11)
        sweep(0);

        // Load frames; frame 5 written invalid (R5)
        for (int f = 0; f < FRAMES; f++) begin
            sup_write(f, (f * 3 + 1) % NBLK, (f != 5), 1'b0);
        end
        sweep(1);

        // Lock frames 2 and 6, reload frame 5 valid (R6, R7)
        sup_write(2, 7, 1'b1, 1'b1);
        sup_write(6, 19, 1'b1, 1'b1);
        sup_write(5, 16, 1'b1, 1'b0);
        sweep(2);

        // R8: grant on frame 0 after clearing its flag by a rewrite
        sup_write(0, 1, 1'b1, 1'b0);
        lookup(1, 4, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        // R9: lookup of old frame-3 block together with a rewrite of frame 3
        lookup(10, 2, 1'b0, 1'b1, 3, 30, 1'b1, 1'b0);
        lookup(10, 2, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        lookup(30, 6, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        // R9: grant and write to the same frame collide: write wins
        lookup(30, 1, 1'b1, 1'b1, 3, 30, 1'b1, 1'b0);

        // R10: duplicate entry makes a multi-hit
        sup_write(7, 1, 1'b1, 1'b0);
        lookup(1, 0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
        lookup(1, 5, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
        sup_write(7, 22, 1'b1, 1'b0);
        lookup(1, 3, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);

        // R2 and R12: a cycle with no request yields a quiet response
        @(negedge clk);
        check("R2 R12 idle response",
              {27'd0, rsp_valid, rsp_hit, rsp_fault, rsp_viol, rsp_multi}, 32'd0);

        finish_run();
    end

endmodule